// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block guards a processor against runaway software. Software arms and services it through a single 32-bit control word written over a valid/ready write port. Each word carries a 7-bit key, a run/stop command bit and an 8-bit start count. Once the watchdog is armed, a write is taken only if its key is the bitwise inverse of the key held from the last accepted write. Software stuck in a loop that repeats one store therefore cannot keep the watchdog quiet.

The down-counter advances on a slow tick enable that arrives from outside the block, typically a few hundred hertz. When the count runs out for the first time, the block raises a non-maskable interrupt and grants a short grace count of `GRACE` ticks. If that grace count also runs out before a valid service write, the block emits a one-cycle system-reset request and the counter stops. Any accepted write lowers the interrupt and starts a fresh sequence.

The write port never applies back-pressure: `wr_ready` is high in every cycle out of reset, so a word is consumed in every cycle that `wr_valid` is high. A consumed word may still be ignored because of its key. Bits 31:16 of the word carry no meaning.

Top module: `keyed_watchdog`

## Requirements
- R1: While reset is low, and afterwards, `nmi` and `rst_req` are low, the counter is stopped, the stored enable is cleared and `wr_ready` stays high. Ticks after reset produce no expiry. The next write is accepted whatever its key.
- R2: While the stored enable (bit 8 of the last accepted word) is clear, a write is accepted whatever its key field holds (bits 15:9).
- R3: While the stored enable is set, a write is ignored entirely if its key (bits 15:9) differs from the bitwise inverse of the stored key. The count in progress, the stage and `nmi` are left unchanged.
- R4: An accepted write stores bit 8 as the new enable and bits 15:9 as the new key. It loads the counter with the start count in bits 7:0.
- R5: An accepted write lowers `nmi` in the following cycle and returns the block to its first stage. It also cancels any pending grace count.
- R6: After an accepted write with bit 8 = 1, the count drops by one on each tick. With bit 8 = 0 the counter holds and never expires.
- R7: The first expiry is the tick that takes the count from 1 to 0. It raises `nmi` from the next cycle, reloads the count with `GRACE` and the counter keeps running. `nmi` then stays high until an accepted write or a reset.
- R8: An expiry during the grace stage drives `rst_req` high for exactly one cycle and stops the counter. `nmi` stays high.
- R9: A start count of 0 behaves as 256 ticks.
- R10: When a tick and an accepted write occur in the same cycle, the write takes effect and the tick is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow count enable, one cycle per tick |
| wr_valid | input | 1 | Control word present on `wr_data` |
| wr_ready | output | 1 | Always high out of reset; the port never stalls |
| wr_data | input | 32 | Control word: key 15:9, run/enable 8, start count 7:0 |
| nmi | output | 1 | Non-maskable interrupt level, first expiry stage |
| rst_req | output | 1 | One-cycle system-reset request, second expiry |

## Verification
The bench keeps the default 7-bit key and 8-bit count field but builds the block with `GRACE` = 3 rather than the default of 1. The grace window therefore spans several ticks, so a service write can land inside it and cancel the reset request, and a wrong-key write can fall between ticks of a live count. The 8-bit field keeps the zero-means-256 case short enough to run to both expiries.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  // Expiry stage of the watchdog
  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_WARNED = 2'd1,
    ST_FIRED  = 2'd2
  } stage_e;
endpackage

// File: rtl/kwd_keygate.sv
// Decides whether a control word is taken and holds enable and key.
module kwd_keygate #(
  parameter int KEY_W = 7,
  parameter int CNT_W = 8,
  localparam int EN_BIT  = CNT_W,
  localparam int KEY_LSB = CNT_W + 1,
  localparam int USED_W  = KEY_LSB + KEY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [USED_W-1:0] wr_word,
  output logic              accept,
  output logic              run_cmd,
  output logic [CNT_W:0]    load_val
);
  logic             en_q;
  logic [KEY_W-1:0] key_q;
  logic [KEY_W-1:0] key_in;
  logic [CNT_W-1:0] cnt_in;
  logic             key_ok;

  assign key_in  = wr_word[KEY_LSB +: KEY_W];
  assign cnt_in  = wr_word[CNT_W-1:0];
  assign run_cmd = wr_word[EN_BIT];
  assign key_ok  = !en_q || (key_in == ~key_q);
  assign accept  = wr_valid && key_ok;

  // a zero field stands for the full 2**CNT_W span
  assign load_val = (cnt_in == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      key_q <= '0;
    end else if (accept) begin
      en_q  <= run_cmd;
      key_q <= key_in;
    end
  end
endmodule

// File: rtl/kwd_counter.sv
// Tick-driven down counter with load, grace reload and halt.
module kwd_counter #(
  parameter int W     = 9,
  parameter int GRACE = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         load_run,
  input  logic         tick,
  input  logic         halt,
  output logic         expire
);
  localparam logic [W-1:0] GRACE_V = W'(GRACE);
  localparam logic [W-1:0] ONE_V   = W'(1);

  logic [W-1:0] cnt_q;
  logic         run_q;

  // a write in the same cycle swallows the tick
  assign expire = tick && run_q && !load && (cnt_q == ONE_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= load_run;
    end else if (tick && run_q) begin
      if (expire) begin
        if (halt) begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end else begin
          cnt_q <= GRACE_V;
        end
      end else begin
        cnt_q <= cnt_q - ONE_V;
      end
    end
  end
endmodule

// File: rtl/kwd_stage.sv
// Two-stage expiry sequencer: interrupt first, reset request second.
module kwd_stage
  import kwd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic expire,
  output logic warned,
  output logic nmi,
  output logic rst_req
);
  stage_e stage_q;
  stage_e stage_d;
  logic   req_q;

  always_comb begin
    stage_d = stage_q;
    if (clear) begin
      stage_d = ST_ARMED;
    end else if (expire) begin
      unique case (stage_q)
        ST_ARMED:  stage_d = ST_WARNED;
        ST_WARNED: stage_d = ST_FIRED;
        default:   stage_d = stage_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= ST_ARMED;
      req_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      req_q   <= !clear && expire && (stage_q == ST_WARNED);
    end
  end

  assign warned  = (stage_q == ST_WARNED);
  assign nmi     = (stage_q != ST_ARMED);
  assign rst_req = req_q;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int DATA_W = 32,
  parameter int KEY_W  = 7,
  parameter int CNT_W  = 8,
  parameter int GRACE  = 1,
  localparam int USED_W = CNT_W + 1 + KEY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              nmi,
  output logic              rst_req
);
  logic           wr_accept;
  logic           run_cmd;
  logic [CNT_W:0] load_val;
  logic           expire;
  logic           warned;

  wire unused_hi = ^wr_data[DATA_W-1:USED_W];

  assign wr_ready = 1'b1;

  kwd_keygate #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_word  (wr_data[USED_W-1:0]),
    .accept   (wr_accept),
    .run_cmd  (run_cmd),
    .load_val (load_val)
  );

  kwd_counter #(.W(CNT_W + 1), .GRACE(GRACE)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_accept),
    .load_val (load_val),
    .load_run (run_cmd),
    .tick     (tick),
    .halt     (warned),
    .expire   (expire)
  );

  kwd_stage u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (wr_accept),
    .expire  (expire),
    .warned  (warned),
    .nmi     (nmi),
    .rst_req (rst_req)
  );
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic wr_ready,
  input logic acc,
  input logic nmi,
  input logic rst_req
);
  p_ready_high_r1: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);

  p_service_lowers_nmi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !nmi);

  p_nmi_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi && !acc) |=> nmi);

  p_nmi_rise_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> $past(tick));

  p_req_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_req_under_nmi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> nmi);
endmodule

bind keyed_watchdog kwd_checker u_kwd_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .wr_ready (wr_ready),
  .acc      (wr_accept),
  .nmi      (nmi),
  .rst_req  (rst_req)
);

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  localparam int GR = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  wire         wr_ready;
  wire         nmi;
  wire         rst_req;

  always #2 clk = ~clk;

  keyed_watchdog #(.GRACE(GR)) i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .nmi(nmi), .rst_req(rst_req)
  );

  int checks = 0;
  int errors = 0;
  int tick_no = 0;
  bit nmi_prev = 1'b0;
  bit done = 1'b0;

  typedef struct { bit is_rst; int at; } ev_t;
  ev_t expq[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Driver: applies a word and pushes the events the model predicts.
  task automatic do_write(int key, bit run, int cnt, bit accepted, bit with_tick);
    @(posedge clk); #1;
    wr_valid = 1'b1;
    wr_data  = {16'h0, key[6:0], run, cnt[7:0]};
    tick     = with_tick;
    if (with_tick) tick_no++;
    @(posedge clk); #1;
    wr_valid = 1'b0;
    tick     = 1'b0;
    if (accepted) begin
      expq.delete();
      if (run) begin
        int n;
        n = (cnt == 0) ? 256 : cnt;       // R4, R9 load rules
        expq.push_back('{1'b0, tick_no + n});
        expq.push_back('{1'b1, tick_no + n + GR});
      end
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      tick = 1'b1;
      tick_no++;
      @(posedge clk); #1;
      tick = 1'b0;
    end
  endtask

  // Monitor: pops expected events as the outputs show them.
  task automatic seen(bit is_rst);
    string req;
    req = is_rst ? "R8" : "R7";
    if (expq.size() == 0) begin
      chk(1'b0, req, "unexpected event at tick", tick_no, -1);
    end else begin
      ev_t e;
      e = expq.pop_front();
      chk(e.is_rst == is_rst, req, "event kind", int'(is_rst), int'(e.is_rst));
      chk(e.at == tick_no, req, "event tick", tick_no, e.at);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (nmi && !nmi_prev) seen(1'b0);
      if (rst_req) seen(1'b1);
    end
    nmi_prev = nmi;
  end

  initial begin
    #(200000 * 4);
    chk(1'b0, "R1", "watchdog expired, cycles", 200000, 0);
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(nmi == 1'b0, "R1", "nmi in reset", int'(nmi), 0);
    chk(rst_req == 1'b0, "R1", "rst_req in reset", int'(rst_req), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ready == 1'b1, "R1", "wr_ready", int'(wr_ready), 1);
    ticks(3);                                  // R1: stopped after reset

    // R2 any key while disabled; R4 load, R6 run; R7 then R8
    do_write(7'h2A, 1'b1, 5, 1'b1, 1'b0);
    ticks(5 + GR);
    ticks(6);                                  // R8: counter halted
    @(negedge clk);
    chk(nmi == 1'b1, "R8", "nmi held after request", int'(nmi), 1);

    // R5 service lowers nmi
    do_write(7'h55, 1'b1, 4, 1'b1, 1'b0);
    @(negedge clk);
    chk(nmi == 1'b0, "R5", "nmi after service", int'(nmi), 0);
    ticks(2);
    // R3 key not inverted: ignored, timing of the live count kept
    do_write(7'h55, 1'b1, 9, 1'b0, 1'b0);
    ticks(2);
    @(negedge clk);
    chk(nmi == 1'b1, "R3", "nmi after ignored write", int'(nmi), 1);
    ticks(1);
    // R5 service inside the grace window cancels the request
    do_write(7'h2A, 1'b1, 3, 1'b1, 1'b0);
    @(negedge clk);
    chk(nmi == 1'b0, "R5", "nmi after grace service", int'(nmi), 0);
    ticks(3 + GR);

    // R6 stop command: no expiry
    do_write(7'h55, 1'b0, 7, 1'b1, 1'b0);
    ticks(20);
    @(negedge clk);
    chk(nmi == 1'b0, "R6", "nmi while stopped", int'(nmi), 0);

    // R9 zero count, any key since enable is clear (R2)
    do_write(7'h11, 1'b1, 0, 1'b1, 1'b0);
    ticks(256 + GR);

    // R10 write and tick together: tick discarded
    do_write(7'h6E, 1'b1, 2, 1'b1, 1'b1);
    ticks(2 + GR);

    // R1 reset mid-sequence
    do_write(7'h11, 1'b1, 3, 1'b1, 1'b0);
    ticks(4);
    @(posedge clk); #1 rst_n = 1'b0;
    expq.delete();
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(nmi == 1'b0, "R1", "nmi after mid-run reset", int'(nmi), 0);
    #1 rst_n = 1'b1;
    ticks(5);
    do_write(7'h33, 1'b1, 2, 1'b1, 1'b0);      // R1 enable cleared: any key
    ticks(2 + GR);

    repeat (2) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    chk(expq.size() == 0, "R7", "missing expected events", expq.size(), 0);
    report();
    $finish;
  end
endmodule